// File: doc/BRIEF.md
# Outbound Message Queue Port

This block serves the outbound direction of a messaging unit. Message frame addresses waiting for an external host sit in a circular list in local memory. The list is a power-of-two number of 32-bit entries and starts at a 1 MiB-aligned base address. A local processor posts entries by writing the list's head offset through a small register port. An external bus master collects the oldest entry by reading a single queue port.

Each port read is accepted with a valid/ready handshake. If the list is not empty, the block issues one 32-bit read to local memory at base plus tail offset. It returns the fetched word on the response channel and then moves the tail one entry forward, wrapping at the end of the list. If head and tail are equal, the list is empty: the block answers at once with an all-ones word, touches no memory and leaves the tail alone. Only one port read is in flight at a time.

Top module: `omq_port`

## Requirements
- R1: A port read accepted while head and tail differ causes exactly one memory request at address {base[31:20], tail byte offset}, with bits 1:0 zero, held until accepted. The returned memory word appears unchanged as the port response data.
- R2: After each port read that fetches an entry, the tail byte offset read back through the register port has grown by 4.
- R3: A port read accepted while head equals tail responds with 0xFFFF_FFFF, issues no memory request and leaves the tail unchanged.
- R4: Hardware never changes the head. Only a register write with reg_addr = 1 (head select) alters it.
- R5: Reading reg_addr = 1 returns base[31:20] in bits 31:20, the head byte offset in bits 19:2 and zero in bits 1:0. On a write, offset bits at or above log2 of the queue size in bytes are dropped and read back as zero.
- R6: Reading reg_addr = 2 returns the tail in the same layout as the head. Register writes to reg_addr = 2 are ignored.
- R7: Reading reg_addr = 0 returns the base register with bits 19:0 forced to zero. Writes keep only bits 31:20. reg_addr = 3 reads as zero.
- R8: After reset, base, head and tail read as zero, no response or memory request is pending, and the port is ready for a read.
- R9: The tail offset wraps from (queue bytes − 4) to 0, so fetches continue from the start of the list.
- R10: A response stays valid with stable data until port_rsp_ready is high. No new port read is accepted from acceptance until the response has been taken.
- R11: A head write made while a fetch is in flight is used by the empty test of the next port read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe from the local processor |
| reg_addr | input | 2 | Register select: 0 base, 1 head, 2 tail, 3 none |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| port_req_valid | input | 1 | External master requests a queue port read |
| port_req_ready | output | 1 | Block can accept a queue port read |
| port_rsp_valid | output | 1 | Queue port read data is valid |
| port_rsp_ready | input | 1 | External master takes the response |
| port_rsp_data | output | 32 | Fetched entry or 0xFFFF_FFFF when empty |
| mem_req_valid | output | 1 | Local memory read request |
| mem_req_ready | input | 1 | Local memory accepts the request |
| mem_req_addr | output | 32 | Local memory byte address |
| mem_rsp_valid | input | 1 | Local memory read data is valid |
| mem_rsp_data | input | 32 | Local memory read data |

## Verification
Register reads are combinational, so a value is due in the same cycle as its select, and a write shows one edge after its strobe. The bench sets the select at a falling edge and samples shortly after it. An empty port read raises its response on the edge that accepts it. A non-empty read puts its memory request out one edge after acceptance. Its response follows one edge after the memory returns data, and the bench model adds a programmable latency. The bench therefore waits for the valid handshakes at falling edges rather than counting fixed delays. It compares data, the fetch address and the pointer readbacks only once a response has been taken.

// File: rtl/omq_pkg.sv
package omq_pkg;

    localparam int BASE_LSB = 20;
    localparam int BASE_W   = 32 - BASE_LSB;
    localparam int OFF_W    = BASE_LSB - 2;

    localparam logic [31:0] EMPTY_WORD = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_HEAD = 2'd1,
        SEL_TAIL = 2'd2,
        SEL_NONE = 2'd3
    } omq_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MREQ  = 2'd1,
        ST_MWAIT = 2'd2,
        ST_RESP  = 2'd3
    } omq_state_e;

    // Layout shared by the head and tail readback and by the fetch address
    typedef struct packed {
        logic [BASE_W-1:0] base_hi;
        logic [OFF_W-1:0]  word_off;
        logic [1:0]        rsvd;
    } omq_ptr_word_t;

    function automatic logic [31:0] ptr_word(input logic [BASE_W-1:0] hi,
                                             input logic [OFF_W-1:0]  off);
        omq_ptr_word_t w;
        w.base_hi  = hi;
        w.word_off = off;
        w.rsvd     = 2'b00;
        return w;
    endfunction

endpackage

// File: rtl/omq_regs.sv
module omq_regs
    import omq_pkg::*;
#(
    parameter  int QLOG2 = 6,
    localparam int IW    = QLOG2 - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              tail_adv,
    output logic [BASE_W-1:0] base_hi,
    output logic [IW-1:0]     head_idx,
    output logic [IW-1:0]     tail_idx
);

    omq_sel_e sel;
    assign sel = omq_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_hi  <= '0;
            head_idx <= '0;
            tail_idx <= '0;
        end else begin
            if (we && sel == SEL_BASE) base_hi <= wdata[31:BASE_LSB];
            if (we && sel == SEL_HEAD) head_idx <= wdata[QLOG2-1:2];
            // entry index wraps by natural overflow at the queue size
            if (tail_adv) tail_idx <= tail_idx + IW'(1);
        end
    end

    always_comb begin
        case (sel)
            SEL_BASE: rdata = {base_hi, {BASE_LSB{1'b0}}};
            SEL_HEAD: rdata = ptr_word(base_hi, OFF_W'(head_idx));
            SEL_TAIL: rdata = ptr_word(base_hi, OFF_W'(tail_idx));
            default:  rdata = '0;
        endcase
    end

    logic unused_wbits;
    assign unused_wbits = ^{wdata[BASE_LSB-1:QLOG2], wdata[1:0]};

    AST_HEAD_SW_ONLY: assert property (@(posedge clk) disable iff (rst)
        !(we && sel == SEL_HEAD) |=> $stable(head_idx)); // R4

    AST_TAIL_HW_ONLY: assert property (@(posedge clk) disable iff (rst)
        !tail_adv |=> $stable(tail_idx)); // R6

endmodule

// File: rtl/omq_ctrl.sv
module omq_ctrl
    import omq_pkg::*;
#(
    parameter  int QLOG2 = 6,
    localparam int IW    = QLOG2 - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_req_valid,
    output logic              port_req_ready,
    output logic              port_rsp_valid,
    input  logic              port_rsp_ready,
    output logic [31:0]       port_rsp_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [31:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    input  logic [BASE_W-1:0] base_hi,
    input  logic [IW-1:0]     head_idx,
    input  logic [IW-1:0]     tail_idx,
    output logic              tail_adv
);

    omq_state_e  st_q;
    logic [31:0] addr_q;
    logic [31:0] data_q;
    logic        q_empty;

    assign q_empty = (head_idx == tail_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (port_req_valid) begin
                        if (q_empty) begin
                            data_q <= EMPTY_WORD;
                            st_q   <= ST_RESP;
                        end else begin
                            addr_q <= ptr_word(base_hi, OFF_W'(tail_idx));
                            st_q   <= ST_MREQ;
                        end
                    end
                end
                ST_MREQ: if (mem_req_ready) st_q <= ST_MWAIT;
                ST_MWAIT: begin
                    if (mem_rsp_valid) begin
                        data_q <= mem_rsp_data;
                        st_q   <= ST_RESP;
                    end
                end
                ST_RESP: if (port_rsp_ready) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign port_req_ready = (st_q == ST_IDLE);
    assign port_rsp_valid = (st_q == ST_RESP);
    assign port_rsp_data  = data_q;
    assign mem_req_valid  = (st_q == ST_MREQ);
    assign mem_req_addr   = addr_q;
    assign tail_adv       = (st_q == ST_MWAIT) && mem_rsp_valid;

    AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> mem_req_addr[1:0] == 2'b00); // R1

    AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R1

    AST_EMPTY_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
        port_req_valid && port_req_ready && (head_idx == tail_idx) |=> !mem_req_valid); // R3

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
        port_req_valid && port_req_ready |=> !port_req_ready); // R10

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        port_rsp_valid && !port_rsp_ready |=> port_rsp_valid && $stable(port_rsp_data)); // R10

endmodule

// File: rtl/omq_port.sv
module omq_port
    import omq_pkg::*;
#(
    parameter int QLOG2 = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        port_req_valid,
    output logic        port_req_ready,
    output logic        port_rsp_valid,
    input  logic        port_rsp_ready,
    output logic [31:0] port_rsp_data,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [31:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data
);

    localparam int IW = QLOG2 - 2;

    logic [BASE_W-1:0] base_hi;
    logic [IW-1:0]     head_idx;
    logic [IW-1:0]     tail_idx;
    logic              tail_adv;

    omq_regs #(.QLOG2(QLOG2)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .tail_adv (tail_adv),
        .base_hi  (base_hi),
        .head_idx (head_idx),
        .tail_idx (tail_idx)
    );

    omq_ctrl #(.QLOG2(QLOG2)) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .port_req_valid (port_req_valid),
        .port_req_ready (port_req_ready),
        .port_rsp_valid (port_rsp_valid),
        .port_rsp_ready (port_rsp_ready),
        .port_rsp_data  (port_rsp_data),
        .mem_req_valid  (mem_req_valid),
        .mem_req_ready  (mem_req_ready),
        .mem_req_addr   (mem_req_addr),
        .mem_rsp_valid  (mem_rsp_valid),
        .mem_rsp_data   (mem_rsp_data),
        .base_hi        (base_hi),
        .head_idx       (head_idx),
        .tail_idx       (tail_idx),
        .tail_adv       (tail_adv)
    );

endmodule

// File: tb/omq_port_tb.sv
`timescale 1ns/1ps
module omq_port_tb;

    localparam int QLOG2 = 6;
    localparam logic [31:0] XKEY = 32'h5A5A_0000;
    localparam logic [31:0] BASE = 32'h3000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        port_req_valid = 1'b0;
    logic        port_req_ready;
    logic        port_rsp_valid;
    logic        port_rsp_ready = 1'b1;
    logic [31:0] port_rsp_data;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    omq_port #(.QLOG2(QLOG2)) u_dut (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .port_req_valid(port_req_valid), .port_req_ready(port_req_ready),
        .port_rsp_valid(port_rsp_valid), .port_rsp_ready(port_rsp_ready),
        .port_rsp_data(port_rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    // local memory model: word at address A holds A ^ XKEY
    assign mem_req_ready = 1'b1;
    logic        mem_busy = 1'b0;
    int          mem_cnt = 0;
    int          mem_lat = 0;
    int          mem_reads = 0;
    logic [31:0] mem_last_addr = '0;

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_busy) begin
            if (mem_cnt == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem_last_addr ^ XKEY;
                mem_busy      <= 1'b0;
            end else begin
                mem_cnt <= mem_cnt - 1;
            end
        end else if (mem_req_valid && mem_req_ready) begin
            mem_busy      <= 1'b1;
            mem_last_addr <= mem_req_addr;
            mem_cnt       <= mem_lat;
            mem_reads     <= mem_reads + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pop_start;
        @(negedge clk);
        while (!port_req_ready) @(negedge clk);
        port_req_valid = 1'b1;
        @(negedge clk);
        port_req_valid = 1'b0;
    endtask

    task automatic pop_finish(output logic [31:0] d);
        while (!port_rsp_valid) @(negedge clk);
        d = port_rsp_data;
        @(negedge clk);
    endtask

    task automatic pop(output logic [31:0] d);
        pop_start();
        pop_finish(d);
    endtask

    // op 0: write head then read it back; op 1: port read; op 2: read tail
    localparam int NV = 6;
    localparam logic [65:0] VEC [NV] = '{
        {2'd0, 32'h0000_000C, 32'h3000_000C},
        {2'd1, 32'h0000_0000, 32'h6A5A_0000},
        {2'd1, 32'h0000_0000, 32'h6A5A_0004},
        {2'd1, 32'h0000_0000, 32'h6A5A_0008},
        {2'd1, 32'h0000_0000, 32'hFFFF_FFFF},
        {2'd2, 32'h0000_0000, 32'h3000_000C}
    };

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int          reads0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R8 reset state
        reg_read(2'd0, v); check("R8 base", v, 32'h0);
        reg_read(2'd1, v); check("R8 head", v, 32'h0);
        reg_read(2'd2, v); check("R8 tail", v, 32'h0);
        check("R8 rsp_valid", {31'b0, port_rsp_valid}, 32'd0);
        check("R8 mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
        check("R8 req_ready", {31'b0, port_req_ready}, 32'd1);

        // R7 base low bits ignored, unused select reads zero
        reg_write(2'd0, 32'h3001_2345);
        reg_read(2'd0, v); check("R7 base", v, BASE);
        reg_read(2'd3, v); check("R7 sel3", v, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [31:0] arg;
            logic [31:0] exp;
            {op, arg, exp} = VEC[i];
            case (op)
                2'd0: begin
                    reg_write(2'd1, arg);
                    reg_read(2'd1, v); check("R5 head readback", v, exp);
                end
                2'd1: begin
                    reads0 = mem_reads;
                    pop(v);
                    if (exp == 32'hFFFF_FFFF) begin
                        check("R3 empty data", v, exp);
                        check("R3 no fetch", mem_reads, reads0);
                    end else begin
                        check("R1 fetched data", v, exp);
                        check("R1 fetch addr", mem_last_addr, exp ^ XKEY);
                    end
                end
                default: begin
                    reg_read(2'd2, v); check("R2 tail readback", v, exp);
                end
            endcase
        end

        // R6 tail writes ignored
        reg_write(2'd2, 32'h0000_0020);
        reg_read(2'd2, v); check("R6 tail after write", v, 32'h3000_000C);

        // R3 empty read keeps tail
        reads0 = mem_reads;
        pop(v);
        check("R3 empty again", v, 32'hFFFF_FFFF);
        check("R3 no fetch again", mem_reads, reads0);
        reg_read(2'd2, v); check("R3 tail kept", v, 32'h3000_000C);

        // R9 wrap: head at 4, tail at 12, entries 12..60 then 0
        reg_write(2'd1, 32'h0000_0004);
        for (int i = 0; i < 14; i++) begin
            logic [31:0] off;
            off = (32'd12 + 32'd4 * i) & 32'h3F;
            pop(v);
            check("R9 wrap data", v, (BASE | off) ^ XKEY);
            check("R1 wrap addr", mem_last_addr, BASE | off);
        end
        reg_read(2'd2, v); check("R9 tail wrapped", v, 32'h3000_0004);
        pop(v); check("R3 empty after wrap", v, 32'hFFFF_FFFF);

        // R5 high offset bits dropped
        reg_write(2'd1, 32'hFFFF_FFFF);
        reg_read(2'd1, v); check("R5 head masked", v, 32'h3000_003C);
        reg_write(2'd1, 32'h0000_0008);

        // R10 response held while not taken
        port_rsp_ready = 1'b0;
        pop_start();
        while (!port_rsp_valid) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            check("R10 rsp held", {31'b0, port_rsp_valid}, 32'd1);
            check("R10 rsp data", port_rsp_data, 32'h6A5A_0004);
            check("R10 no accept", {31'b0, port_req_ready}, 32'd0);
            @(negedge clk);
        end
        port_rsp_ready = 1'b1;
        @(negedge clk);
        check("R10 rsp taken", {31'b0, port_rsp_valid}, 32'd0);
        check("R10 ready again", {31'b0, port_req_ready}, 32'd1);
        reg_read(2'd2, v); check("R2 tail step", v, 32'h3000_0008);

        // R11 head write during fetch
        reg_write(2'd1, 32'h0000_000C);
        mem_lat = 5;
        pop_start();
        reg_write(2'd1, 32'h0000_0010);
        pop_finish(v);
        check("R11 in-flight data", v, 32'h6A5A_0008);
        pop(v);
        check("R11 next uses new head", v, 32'h6A5A_000C);
        reg_read(2'd1, v); check("R4 head untouched", v, 32'h3000_0010);
        pop(v);
        check("R3 final empty", v, 32'hFFFF_FFFF);
        reg_read(2'd2, v); check("R2 final tail", v, 32'h3000_0010);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule